// File: doc/BRIEF.md
# Flash Data-Polling Completion Checker

This block runs on the host side of a parallel flash. It decides whether a program or erase that has already been started on the device has finished. After the command sequence has been written, the host pulses `start_i` with a valid poll address and the value bit 7 of the data will hold when the operation is complete. A valid poll address is the program address for a program, an address inside a sector selected for erase for a sector erase, or any address in an unprotected sector for a chip erase.

The block then reads the device repeatedly over a request/acknowledge read port. It compares status bit 7 of each returned word with the expected value and watches status bit 5, the device's time-limit flag. When the block reaches a verdict, it raises a one-cycle `done_o` together with `pass_o`.

Bit 5 and bit 7 can change in the same read. For that reason, a mismatch that arrives with bit 5 set is never taken as failure straight away. One more read at the same address is made, and bit 7 of that read decides the result. A parameterised limit on ordinary poll reads forces a failure if the device never answers. The limit is turned off when `MAX_POLLS` is 0.

The states are ST_IDLE, ST_POLL, ST_RECHECK and ST_DONE. The transitions are:
- ST_IDLE to ST_POLL on start.
- ST_POLL to ST_POLL on an acknowledged read that shows a mismatch with bit 5 clear, while under the limit.
- ST_POLL to ST_DONE on a match (pass), or when the limit is reached (fail).
- ST_POLL to ST_RECHECK on a mismatch with bit 5 set.
- ST_RECHECK to ST_DONE when the recheck read is acknowledged.
- ST_DONE to ST_IDLE always.

Top module: `flash_poll_checker`

## Requirements
- R1: After reset the block is idle: `busy_o`, `rd_req_o` and `done_o` are 0.
- R2: A `start_i` seen while idle latches `start_addr_i`, and every read of that run is issued at that address.
- R3: An acknowledged poll read whose bit 7 (`rd_data_i[7]`) equals `expect_i` ends the run with `pass_o`=1, and no further reads are made.
- R4: An acknowledged poll read with bit 7 different from `expect_i` and bit 5 (`rd_data_i[5]`) = 0 is followed by another read, unless the poll limit is reached.
- R5: An acknowledged poll read with bit 7 different and bit 5 = 1 is followed by exactly one recheck read. The run then ends with `pass_o`=1 if bit 7 of that recheck read equals `expect_i`, and `pass_o`=0 otherwise.
- R6: When `MAX_POLLS` is non-zero and `MAX_POLLS` poll reads have all mismatched with bit 5 = 0, the run ends with `pass_o`=0 after exactly `MAX_POLLS` reads.
- R7: `done_o` is high for exactly one cycle per run, and `busy_o` is 0 in the cycle after it.
- R8: `start_i` has no effect while `busy_o` is 1. The read address and the number of reads of the run in progress are unchanged.
- R9: Once raised, `rd_req_o` stays high with a stable address until `rd_ack_i` is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a polling run (taken only when idle) |
| start_addr_i | input | ADDR_W | Valid poll address |
| expect_i | input | 1 | Expected final value of status bit 7 |
| busy_o | output | 1 | A run is in progress |
| rd_req_o | output | 1 | Read request, held until acknowledged |
| rd_addr_o | output | ADDR_W | Read address |
| rd_ack_i | input | 1 | Read acknowledge, data valid in the same cycle |
| rd_data_i | input | DATA_W | Read data |
| done_o | output | 1 | One-cycle verdict strobe |
| pass_o | output | 1 | Verdict, valid while `done_o` is high |

## Verification
Two events can fall in the same read: the time-limit flag rising and bit 7 turning to its final value. The bench sweeps the read index at which bit 7 reaches the expected value against the read index at which bit 5 rises, including the cases where they coincide and the case where bit 7 flips exactly on the recheck read. For each pair, the bench computes the verdict and the read count arithmetically and judges them at the ports. It also sweeps the cases in which the poll limit is met before either event, and varies the read latency across reads.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_POLL    = 2'd1,
        ST_RECHECK = 2'd2,
        ST_DONE    = 2'd3
    } poll_state_e;

endpackage

// File: rtl/poll_flag_eval.sv
module poll_flag_eval #(
    parameter int DATA_W    = 8,
    parameter int POLL_BIT  = 7,
    parameter int LIMIT_BIT = 5
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic              expect_i,
    output logic              match_o,
    output logic              limit_o
);
    always_comb begin
        match_o = (data_i[POLL_BIT] == expect_i);
        limit_o = data_i[LIMIT_BIT];
    end
endmodule

// File: rtl/poll_limit_ctr.sv
module poll_limit_ctr #(
    parameter int MAX_POLLS = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic last_o
);
    generate
        if (MAX_POLLS == 0) begin : g_unlimited
            assign last_o = 1'b0;
        end else begin : g_limited
            localparam int CNT_W = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
            localparam logic [CNT_W-1:0] LAST = CNT_W'(MAX_POLLS - 1);
            logic [CNT_W-1:0] cnt_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (clr_i) begin
                    cnt_q <= '0;
                end else if (inc_i && cnt_q != LAST) begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            assign last_o = (cnt_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/flash_poll_checker.sv
module flash_poll_checker
    import flash_poll_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int POLL_BIT  = 7,
    parameter int LIMIT_BIT = 5,
    parameter int MAX_POLLS = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic              expect_i,
    output logic              busy_o,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_ack_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              done_o,
    output logic              pass_o
);
    poll_state_e       state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic              expect_q;
    logic              result_q, result_d;
    logic              bit_match, limit_flag, poll_last;
    logic              take_start, poll_ack;

    poll_flag_eval #(
        .DATA_W   (DATA_W),
        .POLL_BIT (POLL_BIT),
        .LIMIT_BIT(LIMIT_BIT)
    ) u_eval (
        .data_i  (rd_data_i),
        .expect_i(expect_q),
        .match_o (bit_match),
        .limit_o (limit_flag)
    );

    assign take_start = (state_q == ST_IDLE) && start_i;
    assign poll_ack   = (state_q == ST_POLL) && rd_ack_i;

    poll_limit_ctr #(
        .MAX_POLLS(MAX_POLLS)
    ) u_limit (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (take_start),
        .inc_i (poll_ack),
        .last_o(poll_last)
    );

    // next state and verdict
    always_comb begin
        state_d  = state_q;
        result_d = result_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d  = ST_POLL;
                    result_d = 1'b0;
                end
            end
            ST_POLL: begin
                if (rd_ack_i) begin
                    if (bit_match) begin
                        state_d  = ST_DONE;
                        result_d = 1'b1;
                    end else if (limit_flag) begin
                        state_d = ST_RECHECK;
                    end else if (poll_last) begin
                        state_d  = ST_DONE;
                        result_d = 1'b0;
                    end
                end
            end
            ST_RECHECK: begin
                if (rd_ack_i) begin
                    state_d  = ST_DONE;
                    result_d = bit_match;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and run context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            addr_q   <= '0;
            expect_q <= 1'b0;
            result_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            result_q <= result_d;
            if (take_start) begin
                addr_q   <= start_addr_i;
                expect_q <= expect_i;
            end
        end
    end

    // outputs
    always_comb begin
        busy_o    = (state_q != ST_IDLE);
        rd_req_o  = (state_q == ST_POLL) || (state_q == ST_RECHECK);
        rd_addr_o = addr_q;
        done_o    = (state_q == ST_DONE);
        pass_o    = (state_q == ST_DONE) && result_q;
    end
endmodule

// File: rtl/flash_poll_sva.sv
module flash_poll_sva #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic              rd_req_o,
    input logic [ADDR_W-1:0] rd_addr_o,
    input logic              rd_ack_i,
    input logic              done_o,
    input logic              pass_o
);
    a_r1_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!rd_req_o && !done_o));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    a_r8_addr_held_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(rd_addr_o));

    a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_addr_o)));

    a_r3_verdict_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(rd_ack_i && rd_req_o));

    a_r3_pass_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        pass_o |-> done_o);
endmodule

bind flash_poll_checker flash_poll_sva #(.ADDR_W(ADDR_W)) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy_o   (busy_o),
    .rd_req_o (rd_req_o),
    .rd_addr_o(rd_addr_o),
    .rd_ack_i (rd_ack_i),
    .done_o   (done_o),
    .pass_o   (pass_o)
);

// File: tb/tb_flash_poll_checker.sv
module tb_flash_poll_checker;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 8;
    localparam int MAXP       = 4;
    localparam int SPAN       = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [ADDR_W-1:0] start_addr_i = '0;
    logic              expect_i = 1'b0;
    logic              busy_o, rd_req_o, done_o, pass_o;
    logic [ADDR_W-1:0] rd_addr_o;
    logic              rd_ack_i = 1'b0;
    logic [DATA_W-1:0] rd_data_i = '0;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_poll_checker #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .POLL_BIT(7), .LIMIT_BIT(5), .MAX_POLLS(MAXP)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
        .expect_i(expect_i), .busy_o(busy_o), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
        .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i), .done_o(done_o), .pass_o(pass_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one run: bit 7 reaches expect at read n, bit 5 rises at read m
    task automatic run(input int n, input int m, input bit ex, input logic [ADDR_W-1:0] a);
        int  reads = 0;
        int  wait_c = 0;
        int  cyc = 0;
        int  done_cnt = 0;
        bit  got_pass = 1'b0;
        bit  addr_ok = 1'b1;
        int  exp_reads = 0;
        bit  exp_pass = 1'b0;
        bit  finished = 1'b0;
        for (int k = 0; k < 64; k++) begin
            if (k >= n) begin exp_pass = 1'b1; exp_reads = k + 1; break; end
            if (k >= m) begin exp_pass = (k + 1 >= n); exp_reads = k + 2; break; end
            if (k + 1 == MAXP) begin exp_pass = 1'b0; exp_reads = MAXP; break; end
        end
        @(negedge clk);
        start_i = 1'b1; start_addr_i = a; expect_i = ex;
        while (!finished && cyc < 100) begin
            @(negedge clk);
            cyc++;
            // start attempt while busy (R8), other address and expectation
            start_i = (cyc == 1 || cyc == 3);
            start_addr_i = ~a;
            expect_i = ~ex;
            rd_ack_i = 1'b0;
            if (done_o) begin
                done_cnt++;
                got_pass = pass_o;
            end else if (done_cnt > 0) begin
                finished = 1'b1;
                check(done_o == 1'b0 && busy_o == 1'b0, "R7", int'(busy_o), 0);
            end
            if (rd_req_o) begin
                if (rd_addr_o != a) addr_ok = 1'b0;
                if (wait_c == 0) begin
                    logic [DATA_W-1:0] d;
                    d = 8'h5A ^ DATA_W'(reads * 37);
                    d[7] = (reads >= n) ? ex : ~ex;
                    d[5] = (reads >= m);
                    rd_data_i = d;
                    rd_ack_i = 1'b1;
                    reads++;
                    wait_c = reads % 3;
                end else begin
                    wait_c--;
                end
            end
        end
        start_i = 1'b0;
        rd_ack_i = 1'b0;
        check(finished, "R7 watchdog", cyc, 100);
        check(done_cnt == 1, "R7", done_cnt, 1);
        check(addr_ok, "R2/R8 address", 0, 1);
        if (exp_reads == MAXP && !exp_pass && n > MAXP - 1 && m > MAXP - 1)
            check(got_pass == 1'b0 && reads == MAXP, "R6", reads, MAXP);
        else if (n <= m || n == 0)
            check(got_pass == exp_pass && reads == exp_reads, "R3 R4", reads, exp_reads);
        else
            check(got_pass == exp_pass && reads == exp_reads, "R5", int'(got_pass), int'(exp_pass));
        check(got_pass == exp_pass, "R3 R5 R6 verdict", int'(got_pass), int'(exp_pass));
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(busy_o == 1'b0 && rd_req_o == 1'b0 && done_o == 1'b0, "R1", int'(busy_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy_o == 1'b0 && rd_req_o == 1'b0, "R1", int'(rd_req_o), 0);
        // R9: request held across latency, covered by varying wait_c per read
        for (int ex = 0; ex < 2; ex++) begin
            for (int n = 0; n < SPAN; n++) begin
                for (int m = 0; m < SPAN; m++) begin
                    run(n, m, ex[0], ADDR_W'(8'h30 + n * SPAN + m));
                end
            end
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule